// File: doc/BRIEF.md
# Serial Keyboard Protocol Responder

This block answers for a keyboard attached to one channel of a serial controller. The host writes command bytes to the channel's transmit side, and a key source delivers already translated keycodes with a press/release flag. Every byte that the host should receive (command answers and key make/break codes) is queued in a byte FIFO. The host drains that FIFO through the channel's data register.

Three host commands produce answers. A reset command flushes the queue and then loads a three-byte identification sequence. Either of two layout queries flushes the queue and then loads a two-byte layout answer. A set-indicators command makes the block discard the host byte that follows it, because the indicator hardware is not part of this block. The two lock keys (caps and num) pass through a small state filter. A full toggle cycle of a lock key, which is two presses and two releases, then produces exactly one make code and one break code.

The queue takes up to four bytes per cycle: up to three bytes of a command answer and one key byte. Command bytes always go ahead of the key byte. A flush discards a key byte that arrives in the same cycle. Each push or pop that leaves data in the queue raises a one-cycle receive interrupt strobe.

Top module: `kbd_resp_top`

## Requirements
- R1: An accepted host byte 0x01 empties the queue and then enqueues 0xFF, 0x04, 0x7F, in that order.
- R2: An accepted host byte 0x0E arms an indicator flag. The next accepted host byte is swallowed with no effect, whatever its value, and that byte clears the flag.
- R3: An accepted host byte 0x07 or 0x0F empties the queue and then enqueues 0xFE, 0x21.
- R4: Any other accepted host byte leaves the queue and its contents unchanged.
- R5: A key event with press=1 enqueues the keycode. With press=0 it enqueues the keycode with bit 7 set.
- R6: Each lock key (keycodes CAPS_KEY=119 and NUM_KEY=98) has a 2-bit state, cleared at reset. A press flips bit 0 and a release flips bit 1. A press that leaves the state at 2 is dropped, and a release that leaves it at 3 is dropped.
- R7: The queue holds DEPTH=256 bytes and silently drops pushes while full. With the queue empty, rd_data reads 0.
- R8: rx_avail is 1 exactly when the queue holds data. rx_irq pulses for one cycle, in the cycle after a push or pop that leaves the queue non-empty.
- R9: Host bytes are acted on only while tx_enable=1 and chan_disabled=0. Otherwise they have no effect, and they do not touch the indicator flag.
- R10: When a command answer and a key event arrive in the same cycle, the answer bytes are queued before the key byte. A flushing command discards the key byte of its own cycle.
- R11: rd_data shows the oldest queued byte. rd_pop=1 removes it at the clock edge, and bytes leave in the order they arrived.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host wrote a byte to the transmit side |
| host_byte | input | 8 | Byte written by the host |
| tx_enable | input | 1 | Transmitter enabled by channel configuration |
| chan_disabled | input | 1 | Keyboard channel disabled |
| key_valid | input | 1 | Key event present this cycle |
| key_code | input | 8 | Translated keycode (bit 7 zero) |
| key_press | input | 1 | 1 = press, 0 = release |
| rd_pop | input | 1 | Host reads the data register this cycle |
| rd_data | output | 8 | Oldest queued byte, 0 when empty |
| rx_avail | output | 1 | Queue holds at least one byte |
| rx_irq | output | 1 | One-cycle receive interrupt strobe |

## Verification
A host command and a key event can land in the same cycle and compete for the queue. The bench provokes this by raising host_wr with 0x01 and key_valid in the same cycle, on a queue that already holds key bytes. The drained contents must then be exactly 0xFF, 0x04, 0x7F with the queue empty afterwards. A second test pairs the non-flushing 0x0E command with a key event, and that key byte must survive. A third test puts a pop and a push in one cycle, and the expected order and interrupt strobe are worked out from the queue's occupancy.

// File: rtl/kbd_resp_pkg.sv
package kbd_resp_pkg;

  localparam int RESP_MAX = 3;

  typedef struct packed {
    logic                        flush;
    logic                        set_led;
    logic [1:0]                  cnt;
    logic [RESP_MAX-1:0][7:0]    bytes;
  } resp_t;

  typedef struct packed {
    logic [1:0] nxt;
    logic       drop;
  } lock_step_t;

  // Map one host command byte to its answer.
  function automatic resp_t decode_cmd(input logic [7:0] b);
    resp_t r;
    r = '0;
    case (b)
      8'h01: begin
        r.flush = 1'b1;
        r.cnt   = 2'd3;
        r.bytes[0] = 8'hFF;
        r.bytes[1] = 8'h04;
        r.bytes[2] = 8'h7F;
      end
      8'h07, 8'h0F: begin
        r.flush = 1'b1;
        r.cnt   = 2'd2;
        r.bytes[0] = 8'hFE;
        r.bytes[1] = 8'h21;
      end
      8'h0E: r.set_led = 1'b1;
      default: ;
    endcase
    return r;
  endfunction

  function automatic logic [7:0] key_byte(input logic [7:0] code, input logic press);
    return {~press | code[7], code[6:0]};
  endfunction

  function automatic lock_step_t lock_step(input logic [1:0] s, input logic press);
    lock_step_t o;
    o.nxt  = press ? (s ^ 2'b01) : (s ^ 2'b10);
    o.drop = press ? (o.nxt == 2'd2) : (o.nxt == 2'd3);
    return o;
  endfunction

endpackage

// File: rtl/kbd_cmd_engine.sv
module kbd_cmd_engine
  import kbd_resp_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     host_wr,
  input  logic [7:0]               host_byte,
  input  logic                     tx_enable,
  input  logic                     chan_disabled,
  output logic                     flush,
  output logic [RESP_MAX-1:0]      resp_vld,
  output logic [RESP_MAX-1:0][7:0] resp_dat
);

  logic  led_q;
  logic  accept;
  logic  act;
  resp_t dec;

  always_comb begin
    accept = host_wr && tx_enable && !chan_disabled;
    dec    = decode_cmd(host_byte);
    act    = accept && !led_q;
    flush  = act && dec.flush;
    for (int i = 0; i < RESP_MAX; i++) begin
      resp_vld[i] = act && (i < int'(dec.cnt));
      resp_dat[i] = dec.bytes[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      led_q <= 1'b0;
    else if (accept) led_q <= led_q ? 1'b0 : dec.set_led;
  end

  // R2
  led_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && led_q) |=> !led_q);
  // R2
  led_swallow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && led_q) |-> (!flush && resp_vld == '0));
  // R9
  gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_enable || chan_disabled) |=> $stable(led_q));

endmodule

// File: rtl/kbd_lock_filter.sv
module kbd_lock_filter
  import kbd_resp_pkg::*;
#(
  parameter logic [7:0] CAPS_KEY = 8'd119,
  parameter logic [7:0] NUM_KEY  = 8'd98
)(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       key_valid,
  input  logic [7:0] key_code,
  input  logic       key_press,
  output logic       fwd_vld,
  output logic [7:0] fwd_byte
);

  localparam int NLOCK = 2;
  localparam logic [NLOCK-1:0][7:0] LOCK_CODES = {NUM_KEY, CAPS_KEY};

  logic [NLOCK-1:0] hit;
  logic [NLOCK-1:0] drop;

  for (genvar g = 0; g < NLOCK; g++) begin : g_lock
    logic [1:0] st_q;
    lock_step_t stp;
    always_comb begin
      hit[g]  = key_valid && (key_code == LOCK_CODES[g]);
      stp     = lock_step(st_q, key_press);
      drop[g] = hit[g] && stp.drop;
    end
    always_ff @(posedge clk) begin
      if (!rst_n)      st_q <= 2'd0;
      else if (hit[g]) st_q <= stp.nxt;
    end
  end

  assign fwd_vld  = key_valid && (drop == '0);
  assign fwd_byte = key_byte(key_code, key_press);

  // R6
  nonlock_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (key_valid && hit == '0) |-> fwd_vld);

endmodule

// File: rtl/kbd_byte_fifo.sv
module kbd_byte_fifo #(
  parameter int DEPTH = 256,
  parameter int LANES = 4
)(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  flush,
  input  logic [LANES-1:0]      push_vld,
  input  logic [LANES-1:0][7:0] push_dat,
  input  logic                  pop,
  output logic [7:0]            head,
  output logic                  not_empty,
  output logic                  nonempty_next,
  output logic                  any_acc,
  output logic                  pop_done,
  output logic [LANES-1:0]      lane_acc
);

  // DEPTH must be a power of two: pointers wrap on their width.
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;
  localparam int SW = CW + 1;

  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] rptr_q, wptr_q, rptr_d, wptr_d, base_w;
  logic [CW-1:0] cnt_q, cnt_d, base_cnt, off;
  logic [LANES-1:0][AW-1:0] wa;

  always_comb begin
    pop_done = pop && (cnt_q != '0) && !flush;
    base_cnt = flush ? '0 : (cnt_q - CW'(pop_done));
    base_w   = flush ? '0 : wptr_q;
    off      = '0;
    for (int i = 0; i < LANES; i++) begin
      lane_acc[i] = 1'b0;
      wa[i]       = base_w + off[AW-1:0];
      if (push_vld[i] && ((SW'(base_cnt) + SW'(off)) < SW'(DEPTH))) begin
        lane_acc[i] = 1'b1;
        off         = off + 1'b1;
      end
    end
    cnt_d         = base_cnt + off;
    wptr_d        = base_w + off[AW-1:0];
    rptr_d        = flush ? '0 : (rptr_q + AW'(pop_done));
    any_acc       = |lane_acc;
    nonempty_next = (cnt_d != '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rptr_q <= '0;
      wptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      rptr_q <= rptr_d;
      wptr_q <= wptr_d;
      cnt_q  <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < LANES; i++)
      if (lane_acc[i]) mem[wa[i]] <= push_dat[i];
  end

  assign not_empty = (cnt_q != '0);
  assign head      = not_empty ? mem[rptr_q] : 8'h00;

  // R7
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));
  // R7
  full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CW'(DEPTH) && !pop && !flush) |-> (lane_acc == '0));
  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush && !pop && push_vld == '0) |=> $stable(cnt_q));

endmodule

// File: rtl/kbd_resp_top.sv
module kbd_resp_top
  import kbd_resp_pkg::*;
#(
  parameter int         DEPTH    = 256,
  parameter logic [7:0] CAPS_KEY = 8'd119,
  parameter logic [7:0] NUM_KEY  = 8'd98
)(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       host_wr,
  input  logic [7:0] host_byte,
  input  logic       tx_enable,
  input  logic       chan_disabled,
  input  logic       key_valid,
  input  logic [7:0] key_code,
  input  logic       key_press,
  input  logic       rd_pop,
  output logic [7:0] rd_data,
  output logic       rx_avail,
  output logic       rx_irq
);

  localparam int LANES   = RESP_MAX + 1;
  localparam int KEY_LN  = RESP_MAX;

  logic                     flush;
  logic [RESP_MAX-1:0]      resp_vld;
  logic [RESP_MAX-1:0][7:0] resp_dat;
  logic                     key_fwd_vld;
  logic [7:0]               key_fwd_byte;
  logic [LANES-1:0]         push_vld;
  logic [LANES-1:0][7:0]    push_dat;
  logic [LANES-1:0]         lane_acc;
  logic                     any_acc, pop_done, nonempty_next;
  logic                     irq_q;

  kbd_cmd_engine u_cmd (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_byte(host_byte),
    .tx_enable(tx_enable), .chan_disabled(chan_disabled),
    .flush(flush), .resp_vld(resp_vld), .resp_dat(resp_dat)
  );

  kbd_lock_filter #(.CAPS_KEY(CAPS_KEY), .NUM_KEY(NUM_KEY)) u_lock (
    .clk(clk), .rst_n(rst_n), .key_valid(key_valid), .key_code(key_code),
    .key_press(key_press), .fwd_vld(key_fwd_vld), .fwd_byte(key_fwd_byte)
  );

  // Lane order is queue order: answer bytes first, key byte last.
  always_comb begin
    push_vld[RESP_MAX-1:0] = resp_vld;
    push_dat[RESP_MAX-1:0] = resp_dat;
    push_vld[KEY_LN]       = key_fwd_vld && !flush;
    push_dat[KEY_LN]       = key_fwd_byte;
  end

  kbd_byte_fifo #(.DEPTH(DEPTH), .LANES(LANES)) u_fifo (
    .clk(clk), .rst_n(rst_n), .flush(flush), .push_vld(push_vld),
    .push_dat(push_dat), .pop(rd_pop), .head(rd_data), .not_empty(rx_avail),
    .nonempty_next(nonempty_next), .any_acc(any_acc), .pop_done(pop_done),
    .lane_acc(lane_acc)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= (any_acc || pop_done) && nonempty_next;
  end
  assign rx_irq = irq_q;

  // R8
  irq_avail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |-> rx_avail);
  // R10
  flush_drops_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> !lane_acc[KEY_LN]);
  // R1
  flush_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> rx_avail);

endmodule

// File: tb/kbd_resp_top_tb.sv
module kbd_resp_top_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       host_wr = 1'b0;
  logic [7:0] host_byte = 8'h00;
  logic       tx_enable = 1'b1;
  logic       chan_disabled = 1'b0;
  logic       key_valid = 1'b0;
  logic [7:0] key_code = 8'h00;
  logic       key_press = 1'b0;
  logic       rd_pop = 1'b0;
  logic [7:0] rd_data;
  logic       rx_avail;
  logic       rx_irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  kbd_resp_top u_dut (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_byte(host_byte),
    .tx_enable(tx_enable), .chan_disabled(chan_disabled),
    .key_valid(key_valid), .key_code(key_code), .key_press(key_press),
    .rd_pop(rd_pop), .rd_data(rd_data), .rx_avail(rx_avail), .rx_irq(rx_irq)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  // All tasks start and end just after a falling edge.
  task automatic host(input logic [7:0] b);
    host_wr = 1'b1; host_byte = b;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic key(input logic [7:0] c, input logic p);
    key_valid = 1'b1; key_code = c; key_press = p;
    @(negedge clk);
    key_valid = 1'b0;
  endtask

  task automatic pop_chk(input string req, input logic [7:0] exp);
    chk(req, rd_data, exp);
    rd_pop = 1'b1;
    @(negedge clk);
    rd_pop = 1'b0;
  endtask

  task automatic empty_chk(input string req);
    chk(req, {7'd0, rx_avail}, 8'h00);
    chk(req, rd_data, 8'h00);
  endtask

  task automatic t_reset_state;
    chk("R8 reset avail", {7'd0, rx_avail}, 8'h00);
    chk("R8 reset irq", {7'd0, rx_irq}, 8'h00);
    chk("R7 reset data", rd_data, 8'h00);
  endtask

  task automatic t_keys;
    key(8'h2A, 1'b1);
    key(8'h2A, 1'b0);
    key(8'h05, 1'b1);
    pop_chk("R5 press", 8'h2A);
    pop_chk("R5 release", 8'hAA);
    pop_chk("R11 order", 8'h05);
    empty_chk("R11 drained");
  endtask

  task automatic t_lock;
    key(8'd119, 1'b1); key(8'd119, 1'b0); key(8'd119, 1'b1); key(8'd119, 1'b0);
    key(8'd98, 1'b1);  key(8'd98, 1'b0);  key(8'd98, 1'b1);  key(8'd98, 1'b0);
    pop_chk("R6 caps make", 8'd119);
    pop_chk("R6 caps break", 8'hF7);
    pop_chk("R6 num make", 8'd98);
    pop_chk("R6 num break", 8'hE2);
    empty_chk("R6 only one pair each");
  endtask

  task automatic t_reset_cmd;
    key(8'h11, 1'b1); key(8'h12, 1'b1);
    host(8'h01);
    pop_chk("R1 byte0", 8'hFF);
    pop_chk("R1 byte1", 8'h04);
    pop_chk("R1 byte2", 8'h7F);
    empty_chk("R1 flushed");
  endtask

  task automatic t_layout;
    key(8'h13, 1'b1);
    host(8'h07);
    pop_chk("R3 q07 byte0", 8'hFE);
    pop_chk("R3 q07 byte1", 8'h21);
    empty_chk("R3 q07 flushed");
    key(8'h14, 1'b1);
    host(8'h0F);
    pop_chk("R3 q0F byte0", 8'hFE);
    pop_chk("R3 q0F byte1", 8'h21);
    empty_chk("R3 q0F flushed");
  endtask

  task automatic t_led;
    key(8'h15, 1'b1);
    host(8'h0E);
    host(8'h01);
    chk("R2 swallowed head", rd_data, 8'h15);
    host(8'h0F);
    pop_chk("R2 flag cleared b0", 8'hFE);
    pop_chk("R2 flag cleared b1", 8'h21);
    empty_chk("R2 end");
  endtask

  task automatic t_other_and_gate;
    key(8'h16, 1'b1);
    host(8'h05);
    host(8'hAB);
    chk("R4 unknown no effect", rd_data, 8'h16);
    tx_enable = 1'b0;
    host(8'h01);
    chk("R9 tx disabled", rd_data, 8'h16);
    host(8'h0E);
    tx_enable = 1'b1; chan_disabled = 1'b1;
    host(8'h0F);
    chk("R9 chan disabled", rd_data, 8'h16);
    chan_disabled = 1'b0;
    pop_chk("R9 byte kept", 8'h16);
    empty_chk("R9 end");
    host(8'h07);
    pop_chk("R9 gated 0E did not arm", 8'hFE);
    pop_chk("R9 layout b1", 8'h21);
  endtask

  task automatic t_race;
    key(8'h21, 1'b1); key(8'h22, 1'b1);
    host_wr = 1'b1; host_byte = 8'h01;
    key_valid = 1'b1; key_code = 8'h23; key_press = 1'b1;
    @(negedge clk);
    host_wr = 1'b0; key_valid = 1'b0;
    pop_chk("R10 flush first b0", 8'hFF);
    pop_chk("R10 flush first b1", 8'h04);
    pop_chk("R10 flush first b2", 8'h7F);
    empty_chk("R10 key discarded");
    host_wr = 1'b1; host_byte = 8'h0E;
    key_valid = 1'b1; key_code = 8'h24; key_press = 1'b0;
    @(negedge clk);
    host_wr = 1'b0; key_valid = 1'b0;
    host(8'h33);
    pop_chk("R10 key kept with 0E", 8'hA4);
    empty_chk("R10 end");
  endtask

  task automatic t_irq;
    key(8'h31, 1'b1);
    chk("R8 irq after push", {7'd0, rx_irq}, 8'h01);
    chk("R8 avail after push", {7'd0, rx_avail}, 8'h01);
    @(negedge clk);
    chk("R8 irq one cycle", {7'd0, rx_irq}, 8'h00);
    key(8'h32, 1'b1);
    @(negedge clk);
    pop_chk("R8 pop1", 8'h31);
    chk("R8 irq pop leaves data", {7'd0, rx_irq}, 8'h01);
    // pop and push in one cycle
    key_valid = 1'b1; key_code = 8'h34; key_press = 1'b1;
    pop_chk("R11 pop with push", 8'h32);
    key_valid = 1'b0;
    chk("R8 irq pop+push", {7'd0, rx_irq}, 8'h01);
    pop_chk("R11 pushed byte", 8'h34);
    chk("R8 no irq at empty", {7'd0, rx_irq}, 8'h00);
    empty_chk("R8 avail low");
  endtask

  task automatic t_full;
    for (int i = 0; i < 260; i++) key(8'(i % 128), 1'b1);
    chk("R7 full avail", {7'd0, rx_avail}, 8'h01);
    for (int i = 0; i < 256; i++) begin
      if (rd_data !== 8'(i % 128)) begin
        chk("R7 full content", rd_data, 8'(i % 128));
      end
      rd_pop = 1'b1;
      @(negedge clk);
      rd_pop = 1'b0;
    end
    n_chk++;
    empty_chk("R7 extra pushes dropped");
    rd_pop = 1'b1;
    @(negedge clk);
    rd_pop = 1'b0;
    empty_chk("R7 empty read returns 0");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_keys();
    t_lock();
    t_reset_cmd();
    t_layout();
    t_led();
    t_other_and_gate();
    t_race();
    t_irq();
    t_full();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule